// File: doc/BRIEF.md
# CRT Timing Generator

This block produces the horizontal and vertical sync and blank strobes for a raster display. A 12-bit horizontal counter counts dot clocks and a 12-bit vertical counter counts scanlines. Every timing position is measured from the start of retrace, so count 0 is the cycle in which sync goes low. Four values set the shape of each axis: the total length, the sync width, the count at which blanking starts and the count at which blanking ends. A blank window that crosses the wrap point is handled.

Each axis has a preload value and a select bit. In internal mode the counter reloads its preload value when it wraps. In external mode a falling edge on an active-low external sync input reloads the counter, which lets the raster lock to an outside source. In that mode the counter otherwise runs freely and wraps to 0. A simple write port fills a shadow register set. The shadow values are copied into the working set only at a frame boundary, so a frame is never built from a mix of old and new timing. Both counters are visible on output ports.

Top module: `crt_timing_gen`

## Requirements
- R1: The horizontal count (`hCount`) advances by one on every clock. On the clock after it equals horizontal total minus 1 it wraps: to 0 in external mode, or to the horizontal preload in internal mode.
- R2: The vertical count (`vCount`) changes only on a line step. A line step is a horizontal wrap or an external horizontal reload. On a line step it goes up by one, and it wraps once it reaches vertical total minus 1. Between line steps it holds, except for an external vertical reload (R7).
- R3: `hsyncN` is low exactly while `hCount` is below the horizontal sync width. `vsyncN` is low exactly while `vCount` is below the vertical sync width.
- R4: With blank start S and blank end E, `hblankN` is low when S <= hCount < E (if S <= E), or when hCount >= S or hCount < E (if S > E). `vblankN` follows the same rule on `vCount`.
- R5: `vblankStartPulse` is high for exactly the first clock in which `vCount` holds the vertical blank start value after that count has been entered.
- R6: In internal mode, the wrap of an axis loads that axis's preload value.
- R7: In external mode, a falling edge on `extHsyncN` or `extVsyncN` loads the preload value into its counter. The load takes effect 3 clock edges after the input is first sampled low, through two synchroniser flops and an edge detector. An external horizontal load also counts as a line step.
- R8: A falling edge on an external sync input has no effect while its axis is in internal mode.
- R9: While the blank-enable control bit is 0, `hblankN` and `vblankN` are both held low. The sync outputs keep running.
- R10: The register map is: 0 horizontal total, 1 horizontal sync width, 2 horizontal blank start, 3 horizontal blank end, 4 horizontal preload, 5 vertical total, 6 vertical sync width, 7 vertical blank start, 8 vertical blank end, 9 vertical preload, 10 control. The control bits are: bit0 = 1 for internal horizontal sync, bit1 = 1 for internal vertical sync, bit2 = 1 for blank enable. Other addresses are ignored. A write becomes effective only after the next vertical wrap or external vertical reload.
- R11: Reset clears both counters to 0, sets the working and shadow registers to the parameter defaults, and holds `vblankStartPulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register select |
| regWrData | input | 12 | Register write data |
| extHsyncN | input | 1 | External horizontal sync, active low, asynchronous |
| extVsyncN | input | 1 | External vertical sync, active low, asynchronous |
| hCount | output | 12 | Horizontal counter |
| vCount | output | 12 | Vertical counter |
| hsyncN | output | 1 | Horizontal sync, active low |
| hblankN | output | 1 | Horizontal blank, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| vblankN | output | 1 | Vertical blank, active low |
| vblankStartPulse | output | 1 | One-clock pulse on entering the vertical blank start line |

## Verification
The assertions check on every cycle that the horizontal count steps by one away from its wrap, that the vertical count holds between line steps, and that an external load lands on the preload value. They also check that the blank-start pulse never lasts two clocks and that the working registers stay frozen except at a frame boundary. Only the bench's scenarios can show the exact sync and blank edges at their programmed counts, including a blank window that wraps. The same holds for the deferral of a write to the next frame, the three-edge latency of an external sync, an external edge being ignored in internal mode, and the forced blanking.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

  parameter int CNT_W = 12;
  parameter int NUM_AXES = 2;

  typedef struct packed {
    logic [CNT_W-1:0] hTotal;
    logic [CNT_W-1:0] hSyncW;
    logic [CNT_W-1:0] hBlkStart;
    logic [CNT_W-1:0] hBlkEnd;
    logic [CNT_W-1:0] hPre;
    logic [CNT_W-1:0] vTotal;
    logic [CNT_W-1:0] vSyncW;
    logic [CNT_W-1:0] vBlkStart;
    logic [CNT_W-1:0] vBlkEnd;
    logic [CNT_W-1:0] vPre;
    logic             hIntSel;
    logic             vIntSel;
    logic             blankEn;
  } cfg_t;

  typedef struct packed {
    logic hExtLoad;
    logic vExtLoad;
  } strobe_t;

  // True while cnt lies in [startPos, endPos), treating the window as circular.
  function automatic logic inWindow(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] startPos,
                                    input logic [CNT_W-1:0] endPos);
    if (startPos <= endPos) return (cnt >= startPos) && (cnt < endPos);
    else                    return (cnt >= startPos) || (cnt < endPos);
  endfunction

endpackage

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crt_timing_pkg::*;
#(
  parameter cfg_t RST_CFG = '0,
  parameter int   ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extHsyncN,
  input  logic              extVsyncN,
  input  logic              frameEnd,
  output cfg_t              activeCfg,
  output strobe_t           strb
);

  localparam int CTRL_BITS = 3;

  cfg_t shadowCfg;
  logic unusedCtrlBits;
  assign unusedCtrlBits = ^wrData[CNT_W-1:CTRL_BITS];

  // Shadow register file: written at any time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= RST_CFG;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(0):  shadowCfg.hTotal    <= wrData;
        ADDR_W'(1):  shadowCfg.hSyncW    <= wrData;
        ADDR_W'(2):  shadowCfg.hBlkStart <= wrData;
        ADDR_W'(3):  shadowCfg.hBlkEnd   <= wrData;
        ADDR_W'(4):  shadowCfg.hPre      <= wrData;
        ADDR_W'(5):  shadowCfg.vTotal    <= wrData;
        ADDR_W'(6):  shadowCfg.vSyncW    <= wrData;
        ADDR_W'(7):  shadowCfg.vBlkStart <= wrData;
        ADDR_W'(8):  shadowCfg.vBlkEnd   <= wrData;
        ADDR_W'(9):  shadowCfg.vPre      <= wrData;
        ADDR_W'(10): begin
          shadowCfg.hIntSel <= wrData[0];
          shadowCfg.vIntSel <= wrData[1];
          shadowCfg.blankEn <= wrData[2];
        end
        default: ;
      endcase
    end
  end

  // Working set: copied only at a frame boundary.
  always_ff @(posedge clk) begin
    if (!rstN)         activeCfg <= RST_CFG;
    else if (frameEnd) activeCfg <= shadowCfg;
  end

  // External sync front end: two-flop synchroniser plus falling-edge detect.
  logic [NUM_AXES-1:0] extIn;
  logic [NUM_AXES-1:0] fallEdge;
  assign extIn = {extVsyncN, extHsyncN};

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_sync
    logic stage1, stage2, stagePrev;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1    <= 1'b1;
        stage2    <= 1'b1;
        stagePrev <= 1'b1;
      end else begin
        stage1    <= extIn[i];
        stage2    <= stage1;
        stagePrev <= stage2;
      end
    end
    assign fallEdge[i] = stagePrev & ~stage2;
  end

  assign strb.hExtLoad = fallEdge[0] & ~activeCfg.hIntSel;
  assign strb.vExtLoad = fallEdge[1] & ~activeCfg.vIntSel;

  // R10: working registers change only at a frame boundary
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(activeCfg));

endmodule

// File: rtl/crt_timing_dp.sv
module crt_timing_dp
  import crt_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             hsyncN,
  output logic             hblankN,
  output logic             vsyncN,
  output logic             vblankN,
  output logic             vbStartPulse,
  output logic             frameEnd
);

  logic             hAtEnd, vAtEnd, lineStep, vAdvance;
  logic [CNT_W-1:0] hNext, vNext, hWrapVal, vWrapVal;

  assign hAtEnd   = (hCount == cfg.hTotal - 1'b1);
  assign vAtEnd   = (vCount == cfg.vTotal - 1'b1);
  assign hWrapVal = cfg.hIntSel ? cfg.hPre : '0;
  assign vWrapVal = cfg.vIntSel ? cfg.vPre : '0;
  assign lineStep = hAtEnd | strb.hExtLoad;
  assign vAdvance = lineStep | strb.vExtLoad;
  assign frameEnd = strb.vExtLoad | (lineStep & vAtEnd);

  always_comb begin
    if (strb.hExtLoad)  hNext = cfg.hPre;
    else if (hAtEnd)    hNext = hWrapVal;
    else                hNext = hCount + 1'b1;

    if (strb.vExtLoad)  vNext = cfg.vPre;
    else if (lineStep)  vNext = vAtEnd ? vWrapVal : vCount + 1'b1;
    else                vNext = vCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount       <= '0;
      vCount       <= '0;
      vbStartPulse <= 1'b0;
    end else begin
      hCount       <= hNext;
      vCount       <= vNext;
      vbStartPulse <= vAdvance && (vNext == cfg.vBlkStart);
    end
  end

  assign hsyncN  = !(hCount < cfg.hSyncW);
  assign vsyncN  = !(vCount < cfg.vSyncW);
  assign hblankN = cfg.blankEn & ~inWindow(hCount, cfg.hBlkStart, cfg.hBlkEnd);
  assign vblankN = cfg.blankEn & ~inWindow(vCount, cfg.vBlkStart, cfg.vBlkEnd);

  // R1: away from its wrap and with no external load, the line counter steps by one
  a_r1_h_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hExtLoad && !hAtEnd) |=> hCount == CNT_W'($past(hCount) + 1'b1));

  // R2: the line number holds between line steps
  a_r2_v_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(lineStep || strb.vExtLoad) |=> $stable(vCount));

  // R7: an external horizontal load lands on the preload value
  a_r7_h_ext_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.hExtLoad |=> hCount == $past(cfg.hPre));

  // R5: the blank-start pulse lasts a single clock (for lines longer than one clock)
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (vbStartPulse && cfg.hTotal > 1) |=> !vbStartPulse);

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_timing_pkg::*;
#(
  parameter int ADDR_W          = 4,
  parameter int DEF_H_TOTAL     = 20,
  parameter int DEF_H_SYNC      = 3,
  parameter int DEF_H_BLK_START = 16,
  parameter int DEF_H_BLK_END   = 5,
  parameter int DEF_V_TOTAL     = 10,
  parameter int DEF_V_SYNC      = 2,
  parameter int DEF_V_BLK_START = 8,
  parameter int DEF_V_BLK_END   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              extHsyncN,
  input  logic              extVsyncN,
  output logic [CNT_W-1:0]  hCount,
  output logic [CNT_W-1:0]  vCount,
  output logic              hsyncN,
  output logic              hblankN,
  output logic              vsyncN,
  output logic              vblankN,
  output logic              vblankStartPulse
);

  localparam cfg_t RST_CFG = '{
    hTotal:    CNT_W'(DEF_H_TOTAL),
    hSyncW:    CNT_W'(DEF_H_SYNC),
    hBlkStart: CNT_W'(DEF_H_BLK_START),
    hBlkEnd:   CNT_W'(DEF_H_BLK_END),
    hPre:      '0,
    vTotal:    CNT_W'(DEF_V_TOTAL),
    vSyncW:    CNT_W'(DEF_V_SYNC),
    vBlkStart: CNT_W'(DEF_V_BLK_START),
    vBlkEnd:   CNT_W'(DEF_V_BLK_END),
    vPre:      '0,
    hIntSel:   1'b1,
    vIntSel:   1'b1,
    blankEn:   1'b1
  };

  cfg_t    activeCfg;
  strobe_t strb;
  logic    frameEnd;

  crt_timing_ctrl #(.RST_CFG(RST_CFG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .wrAddr    (regAddr),
    .wrData    (regWrData),
    .extHsyncN (extHsyncN),
    .extVsyncN (extVsyncN),
    .frameEnd  (frameEnd),
    .activeCfg (activeCfg),
    .strb      (strb)
  );

  crt_timing_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfg          (activeCfg),
    .strb         (strb),
    .hCount       (hCount),
    .vCount       (vCount),
    .hsyncN       (hsyncN),
    .hblankN      (hblankN),
    .vsyncN       (vsyncN),
    .vblankN      (vblankN),
    .vbStartPulse (vblankStartPulse),
    .frameEnd     (frameEnd)
  );

endmodule

// File: tb/crt_timing_gen_tb.sv
`timescale 1ns/1ps
module crt_timing_gen_tb;

  localparam int WD_CYCLES = 200000;
  localparam int VEC_N = 14;
  // {cycle after reset, hCount, vCount, flags{hsyncN,hblankN,vsyncN,vblankN,pulse}}
  // Defaults: hTotal 20, hSync 3, hBlank 16..5, vTotal 10, vSync 2, vBlank 8..3
  localparam int VEC [VEC_N][4] = '{
    '{0,   0,  0, 5'b00000},
    '{2,   2,  0, 5'b00000},
    '{3,   3,  0, 5'b10000},
    '{5,   5,  0, 5'b11000},
    '{15,  15, 0, 5'b11000},
    '{16,  16, 0, 5'b10000},
    '{19,  19, 0, 5'b10000},
    '{20,  0,  1, 5'b00000},
    '{42,  2,  2, 5'b00100},
    '{65,  5,  3, 5'b11110},
    '{160, 0,  8, 5'b00101},
    '{161, 1,  8, 5'b00100},
    '{199, 19, 9, 5'b10100},
    '{200, 0,  0, 5'b00000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [11:0] regWrData = '0;
  logic        extHsyncN = 1'b1;
  logic        extVsyncN = 1'b1;
  logic [11:0] hCount, vCount;
  logic        hsyncN, hblankN, vsyncN, vblankN, vblankStartPulse;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  crt_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .extHsyncN(extHsyncN), .extVsyncN(extVsyncN),
    .hCount(hCount), .vCount(vCount), .hsyncN(hsyncN), .hblankN(hblankN),
    .vsyncN(vsyncN), .vblankN(vblankN), .vblankStartPulse(vblankStartPulse)
  );

  function automatic int flags();
    return int'({hsyncN, hblankN, vsyncN, vblankN, vblankStartPulse});
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    extHsyncN = 1'b1;
    extVsyncN = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic writeReg(input int addr, input int data);
    regWrEn = 1'b1;
    regAddr = 4'(addr);
    regWrData = 12'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    #(WD_CYCLES * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    // R11: reset state
    doReset();
    check("R11 hCount after reset", int'(hCount), 0);
    check("R11 vCount after reset", int'(vCount), 0);
    check("R11 flags after reset", flags(), 5'b00000);

    // Table walk: R1 R2 R3 R4 R5 under default timing
    for (int i = 0; i < VEC_N; i++) begin
      waitCyc(VEC[i][0]);
      check("R1 hCount", int'(hCount), VEC[i][1]);
      check("R2 vCount", int'(vCount), VEC[i][2]);
      check("R3 R4 R5 flags", flags(), VEC[i][3]);
    end

    // R11: reset in mid-frame returns counters to zero
    waitCyc(237);
    doReset();
    check("R11 mid-frame reset hCount", int'(hCount), 0);
    check("R11 mid-frame reset vCount", int'(vCount), 0);

    // R10: new line length deferred to the next frame
    waitCyc(3);
    writeReg(0, 30);
    waitCyc(20);
    check("R10 old length still used", int'(hCount), 0);
    check("R10 old length vCount", int'(vCount), 1);
    waitCyc(200);
    check("R10 frame boundary hCount", int'(hCount), 0);
    waitCyc(220);
    check("R10 new length hCount", int'(hCount), 20);
    check("R10 new length vCount", int'(vCount), 0);
    waitCyc(230);
    check("R10 new length wrap", int'(hCount), 0);
    check("R10 new length line", int'(vCount), 1);

    // R9: blank enable cleared forces blanks low after the frame boundary
    doReset();
    waitCyc(3);
    writeReg(10, 3);
    waitCyc(65);
    check("R9 blank not yet forced", flags(), 5'b11110);
    waitCyc(265);
    check("R9 blanks forced low", flags(), 5'b10100);
    check("R9 counter keeps running", int'(hCount), 5);

    // R6: internal wrap loads preload
    doReset();
    waitCyc(3);
    writeReg(4, 4);
    writeReg(9, 2);
    waitCyc(200);
    check("R6 frame wrap uses old preload", int'(vCount), 0);
    waitCyc(220);
    check("R6 hCount wraps to preload", int'(hCount), 4);
    check("R6 vCount after preload wrap", int'(vCount), 1);
    waitCyc(236);
    check("R6 shortened line hCount", int'(hCount), 4);
    check("R6 shortened line vCount", int'(vCount), 2);

    // R8 then R7: horizontal external sync
    doReset();
    waitCyc(3);
    writeReg(10, 6);
    waitCyc(50);
    extHsyncN = 1'b0;
    waitCyc(55);
    check("R8 ext edge ignored hCount", int'(hCount), 15);
    check("R8 ext edge ignored vCount", int'(vCount), 2);
    waitCyc(60);
    extHsyncN = 1'b1;
    waitCyc(203);
    extHsyncN = 1'b0;
    waitCyc(205);
    check("R7 load not before third edge", int'(hCount), 5);
    waitCyc(206);
    check("R7 ext h load hCount", int'(hCount), 0);
    check("R7 ext h load is a line step", int'(vCount), 1);
    waitCyc(207);
    check("R7 counting resumes", int'(hCount), 1);

    // R7: vertical external sync
    doReset();
    waitCyc(3);
    writeReg(10, 5);
    writeReg(9, 5);
    waitCyc(223);
    extVsyncN = 1'b0;
    waitCyc(226);
    check("R7 ext v load vCount", int'(vCount), 5);
    check("R7 ext v load leaves hCount", int'(hCount), 6);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule